// File: doc/BRIEF.md
# Parallel Flash Query and Sector Map Prober

This block brings up a parallel NOR flash bus on its own after reset. It puts the device into query mode and checks the three-character query signature. It then walks the query table one byte at a time. From that table it takes the command-set identifier, the size exponents, the timeout exponents and the erase-region descriptors. The result is a table of sector start addresses, a sector count, the device and write-buffer sizes, and three timeout values. Each size and timeout is scaled as needed when several narrow chips share one wide port.

The flash side is a plain synchronous port. A read is a one-cycle `fl_rd` strobe, and the device returns the word registered on the following cycle. A write is a one-cycle `fl_we` strobe that carries a command word. When the probe ends the block writes the return-to-array command and pulses `done`. It stays idle until the next reset. Software or a boot sequencer reads the sector map through a small index/lookup port.

Top module: `cfi_probe`

## Requirements
- R1: The first two bus operations after reset are writes: the array command 0xFF at byte address 0, then the query command 0x98 at byte address 0x55 × PORT_BYTES.
- R2: A command word carries the command byte in every byte lane i with i mod CHIP_BYTES = 0 and zero in the other lanes (lane i is bits 8i+7..8i). For 4-byte ports and 2-byte chips: 0x00FF00FF and 0x00980098.
- R3: Query offset k is read at byte address k × PORT_BYTES. Only byte lane 0 (bits 7..0) of the returned word is used. A 16-bit value comes from offsets k (low byte) and k+1 (high byte).
- R4: Offsets 0x10, 0x11 and 0x12 must read 0x51, 0x52 and 0x59. On the first mismatch the probe finishes with `valid` = 0, `cmdset` = 0 and `sect_count` = 0. `valid` changes only in the cycle `done` is high.
- R5: `cmdset` reports the 16-bit identifier at 0x13. Values 1 or 3 give 1, values 2 or 4 give 2, and anything else gives 0.
- R6: `dev_size` = 2^(byte at 0x27) × PORT_BYTES/CHIP_BYTES. A value of 2^32 or more saturates to all ones.
- R7: `wbuf_size` = 2^(16-bit value at 0x2A), saturated the same way.
- R8: The timeouts are 2^(a+b), saturated. For the single-word write, a and b are the bytes at 0x1F and 0x23. For the buffer write they are at 0x20 and 0x24. For the block erase they are at 0x21 and 0x25.
- R9: The region count is the byte at 0x2C. Region r has a 4-byte descriptor at 0x2D+4r. Its bytes 0–1 hold the sector count minus one. Its bytes 2–3 hold the sector size in 256-byte units, where 0 means 128 bytes. Sector starts begin at 0, and each one is the previous start plus the sector size × PORT_BYTES/CHIP_BYTES. The count grows by at most one per cycle.
- R10: At most MAX_REGIONS regions are expanded. A larger region count sets `map_ovf`.
- R11: At most MAX_SECTORS entries are stored, and `sect_count` never exceeds MAX_SECTORS. A sector beyond the cap sets `map_ovf`. Exactly filling the table with the last region does not set it.
- R12: The probe ends with a write of 0xFF at address 0. `done` is high for exactly one cycle, in the cycle right after that write. No bus operation follows until reset.
- R13: `fl_rd` and `fl_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; probe starts on release |
| fl_rd | output | 1 | Flash read strobe |
| fl_we | output | 1 | Flash command write strobe |
| fl_addr | output | FA_W | Flash byte address |
| fl_wdata | output | 8×PORT_BYTES | Command word |
| fl_rdata | input | 8×PORT_BYTES | Read word, valid the cycle after `fl_rd` |
| done | output | 1 | One-cycle end-of-probe pulse |
| valid | output | 1 | Signature found |
| cmdset | output | 2 | Command-set class: 0 other, 1 status-register style, 2 unlock-cycle style |
| dev_size | output | VAL_W | Total device bytes |
| wbuf_size | output | VAL_W | Write-buffer bytes |
| tmo_word | output | VAL_W | Single-word write timeout |
| tmo_buf | output | VAL_W | Buffer write timeout |
| tmo_erase | output | VAL_W | Block erase timeout |
| sect_count | output | clog2(MAX_SECTORS+1) | Sectors stored |
| map_ovf | output | 1 | Region or sector limit exceeded |
| tbl_idx | input | clog2(MAX_SECTORS) | Sector table index |
| tbl_base | output | ADDR_W | Start byte address of sector `tbl_idx` |

## Verification
Two events can fall in the same cycle: the store of the final sector of the last region, and the table reaching its capacity. The design must then finish cleanly, with no overflow. Directed cases build region sets whose totals are exactly MAX_SECTORS and MAX_SECTORS+1. A further case exceeds MAX_REGIONS while the capacity is not reached. In each case the bench judges `sect_count`, `map_ovf` and every table entry against a map it computes itself. Randomized query tables, with junk in the unused byte lanes, cover the decoding and saturation of the sizes and timeouts.

// File: rtl/cfi_probe_pkg.sv
package cfi_probe_pkg;

   typedef enum logic [1:0] {
      CS_OTHER  = 2'd0,
      CS_STATUS = 2'd1,
      CS_UNLOCK = 2'd2
   } cmdset_e;

   typedef enum logic [2:0] {
      ST_RST,
      ST_QRY,
      ST_RREQ,
      ST_RCAP,
      ST_EXP,
      ST_FIN,
      ST_DONE,
      ST_IDLE
   } state_e;

   // query-table offsets the decoder depends on
   localparam logic [7:0] OFF_SIG0   = 8'h10;
   localparam logic [7:0] OFF_SIG1   = 8'h11;
   localparam logic [7:0] OFF_SIG2   = 8'h12;
   localparam logic [7:0] OFF_ID_LO  = 8'h13;
   localparam logic [7:0] OFF_ID_HI  = 8'h14;
   localparam logic [7:0] OFF_TW_TYP = 8'h1F;
   localparam logic [7:0] OFF_TB_TYP = 8'h20;
   localparam logic [7:0] OFF_TE_TYP = 8'h21;
   localparam logic [7:0] OFF_TW_MAX = 8'h23;
   localparam logic [7:0] OFF_TB_MAX = 8'h24;
   localparam logic [7:0] OFF_TE_MAX = 8'h25;
   localparam logic [7:0] OFF_SIZE   = 8'h27;
   localparam logic [7:0] OFF_WBUF_L = 8'h2A;
   localparam logic [7:0] OFF_WBUF_H = 8'h2B;
   localparam logic [7:0] OFF_NREG   = 8'h2C;
   localparam logic [7:0] OFF_DESC   = 8'h2D;
   localparam logic [7:0] OFF_ENTER  = 8'h55;

   localparam logic [7:0] CMD_QUERY  = 8'h98;
   localparam logic [7:0] CMD_ARRAY  = 8'hFF;

endpackage

// File: rtl/cfi_cmd_lanes.sv
module cfi_cmd_lanes #(
   parameter int PORT_BYTES = 4,
   parameter int CHIP_BYTES = 2,
   localparam int DW = 8 * PORT_BYTES
) (
   input  logic [7:0]    cmd_i,
   output logic [DW-1:0] word_o
);
   for (genvar i = 0; i < PORT_BYTES; i++) begin : g_lane
      if ((i % CHIP_BYTES) == 0) begin : g_cmd
         assign word_o[8*i +: 8] = cmd_i;
      end else begin : g_zero
         assign word_o[8*i +: 8] = 8'h00;
      end
   end
endmodule

// File: rtl/cfi_pow2_sat.sv
module cfi_pow2_sat #(
   parameter int EW = 9,
   parameter int W  = 32
) (
   input  logic [EW-1:0] exp_i,
   output logic [W-1:0]  val_o
);
   always_comb begin
      if (32'(exp_i) >= 32'(W)) val_o = '1;
      else                      val_o = W'(1) << exp_i;
   end
endmodule

// File: rtl/cfi_sector_table.sv
module cfi_sector_table #(
   parameter int DEPTH = 64,
   parameter int AW    = 32,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [AW-1:0] wdata,
   input  logic [IW-1:0] ridx,
   output logic [AW-1:0] rdata
);
   logic [AW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= wdata;
   end

   assign rdata = mem[ridx];
endmodule

// File: rtl/cfi_probe.sv
module cfi_probe
   import cfi_probe_pkg::*;
#(
   parameter int PORT_BYTES  = 4,
   parameter int CHIP_BYTES  = 2,
   parameter int FA_W        = 16,
   parameter int ADDR_W      = 32,
   parameter int VAL_W       = 32,
   parameter int MAX_REGIONS = 4,
   parameter int MAX_SECTORS = 64,
   localparam int DW    = 8 * PORT_BYTES,
   localparam int IDX_W = $clog2(MAX_SECTORS),
   localparam int CNT_W = $clog2(MAX_SECTORS + 1)
) (
   input  logic              clk,
   input  logic              rst,
   output logic              fl_rd,
   output logic              fl_we,
   output logic [FA_W-1:0]   fl_addr,
   output logic [DW-1:0]     fl_wdata,
   input  logic [DW-1:0]     fl_rdata,
   output logic              done,
   output logic              valid,
   output logic [1:0]        cmdset,
   output logic [VAL_W-1:0]  dev_size,
   output logic [VAL_W-1:0]  wbuf_size,
   output logic [VAL_W-1:0]  tmo_word,
   output logic [VAL_W-1:0]  tmo_buf,
   output logic [VAL_W-1:0]  tmo_erase,
   output logic [CNT_W-1:0]  sect_count,
   output logic              map_ovf,
   input  logic [IDX_W-1:0]  tbl_idx,
   output logic [ADDR_W-1:0] tbl_base
);
   localparam int RATIO      = PORT_BYTES / CHIP_BYTES;
   localparam int RATIO_LOG2 = $clog2(RATIO);
   localparam int PB_LOG2    = $clog2(PORT_BYTES);

   // elaboration-time parameter checks
   if (PORT_BYTES < 1 || PORT_BYTES > 8 || (PORT_BYTES & (PORT_BYTES - 1)) != 0) begin : g_bad_pb
      $error("PORT_BYTES must be 1, 2, 4 or 8");
   end
   if (CHIP_BYTES < 1 || CHIP_BYTES > PORT_BYTES || (CHIP_BYTES & (CHIP_BYTES - 1)) != 0) begin : g_bad_cb
      $error("CHIP_BYTES must be a power of two no wider than the port");
   end
   if (FA_W < 8 + PB_LOG2) begin : g_bad_fa
      $error("FA_W too narrow for the query window");
   end
   if (ADDR_W < 26) begin : g_bad_aw
      $error("ADDR_W must hold a 16-bit size field scaled by 256");
   end
   if (MAX_REGIONS < 1 || MAX_REGIONS > 255 || MAX_SECTORS < 2) begin : g_bad_lim
      $error("region or sector limit out of range");
   end

   state_e            st;
   logic [7:0]        off, nreg, reg_idx, esz;
   logic [15:0]       cs_id, ebuf;
   logic [7:0]        typ [3];
   logic [7:0]        mx  [3];
   logic [23:0]       desc;
   logic [16:0]       rem;
   logic [ADDR_W-1:0] ssize, base_acc;
   logic [CNT_W-1:0]  cnt;
   logic              sig_ok, valid_q, ovf_q;

   logic [7:0]        rb;
   logic              sig_bad, in_reg, full, last_sect, last_reg, reg_cap;
   logic [7:0]        desc_rel;
   logic [15:0]       size_field;
   logic [ADDR_W-1:0] size_unit, ssize_next;

   assign rb = fl_rdata[7:0];

   if (DW > 8) begin : g_hi
      logic unused_lanes;
      assign unused_lanes = ^fl_rdata[DW-1:8];
   end

   always_comb begin
      case (off)
         OFF_SIG0: sig_bad = (rb != 8'h51);
         OFF_SIG1: sig_bad = (rb != 8'h52);
         OFF_SIG2: sig_bad = (rb != 8'h59);
         default:  sig_bad = 1'b0;
      endcase
   end

   assign in_reg     = (off >= OFF_DESC);
   assign desc_rel   = off - OFF_DESC;
   assign full       = (cnt == CNT_W'(MAX_SECTORS));
   assign last_sect  = (rem == 17'd1);
   assign last_reg   = ((reg_idx + 8'd1) == nreg);
   assign reg_cap    = (reg_idx == 8'(MAX_REGIONS - 1));
   assign size_field = {rb, desc[23:16]};
   assign size_unit  = (size_field == 16'd0) ? ADDR_W'(128) : ADDR_W'({size_field, 8'h00});
   assign ssize_next = size_unit << RATIO_LOG2;

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_RST;
         off      <= OFF_SIG0;
         nreg     <= '0;
         reg_idx  <= '0;
         esz      <= '0;
         cs_id    <= '0;
         ebuf     <= '0;
         for (int i = 0; i < 3; i++) begin
            typ[i] <= '0;
            mx[i]  <= '0;
         end
         desc     <= '0;
         rem      <= '0;
         ssize    <= '0;
         base_acc <= '0;
         cnt      <= '0;
         sig_ok   <= 1'b0;
         valid_q  <= 1'b0;
         ovf_q    <= 1'b0;
      end else begin
         case (st)
            ST_RST:  st <= ST_QRY;
            ST_QRY:  st <= ST_RREQ;
            ST_RREQ: st <= ST_RCAP;
            ST_RCAP: begin
               off <= off + 8'd1;
               if (!in_reg) begin
                  case (off)
                     OFF_ID_LO:  cs_id[7:0]  <= rb;
                     OFF_ID_HI:  cs_id[15:8] <= rb;
                     OFF_TW_TYP: typ[0]      <= rb;
                     OFF_TB_TYP: typ[1]      <= rb;
                     OFF_TE_TYP: typ[2]      <= rb;
                     OFF_TW_MAX: mx[0]       <= rb;
                     OFF_TB_MAX: mx[1]       <= rb;
                     OFF_TE_MAX: mx[2]       <= rb;
                     OFF_SIZE:   esz         <= rb;
                     OFF_WBUF_L: ebuf[7:0]   <= rb;
                     OFF_WBUF_H: ebuf[15:8]  <= rb;
                     OFF_NREG:   nreg        <= rb;
                     default: ;
                  endcase
                  if (off == OFF_SIG2 && !sig_bad) sig_ok <= 1'b1;
                  if (sig_bad)              st <= ST_FIN;
                  else if (off == OFF_NREG) st <= (rb == 8'd0) ? ST_FIN : ST_RREQ;
                  else                      st <= ST_RREQ;
               end else begin
                  case (desc_rel[1:0])
                     2'd0: desc[7:0]   <= rb;
                     2'd1: desc[15:8]  <= rb;
                     2'd2: desc[23:16] <= rb;
                     default: begin
                        rem   <= {1'b0, desc[15:0]} + 17'd1;
                        ssize <= ssize_next;
                     end
                  endcase
                  st <= (desc_rel[1:0] == 2'd3) ? ST_EXP : ST_RREQ;
               end
            end
            ST_EXP: begin
               if (full) begin
                  ovf_q <= 1'b1;
                  st    <= ST_FIN;
               end else begin
                  cnt      <= cnt + CNT_W'(1);
                  base_acc <= base_acc + ssize;
                  rem      <= rem - 17'd1;
                  if (last_sect) begin
                     if (last_reg) begin
                        st <= ST_FIN;
                     end else if (reg_cap) begin
                        ovf_q <= 1'b1;
                        st    <= ST_FIN;
                     end else begin
                        reg_idx <= reg_idx + 8'd1;
                        st      <= ST_RREQ;
                     end
                  end
               end
            end
            ST_FIN: begin
               valid_q <= sig_ok;
               st      <= ST_DONE;
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // bus side
   logic [7:0] cmd_byte;
   assign cmd_byte = (st == ST_QRY) ? CMD_QUERY : CMD_ARRAY;
   assign fl_we    = (st == ST_RST) || (st == ST_QRY) || (st == ST_FIN);
   assign fl_rd    = (st == ST_RREQ);

   always_comb begin
      case (st)
         ST_QRY:  fl_addr = FA_W'(OFF_ENTER) << PB_LOG2;
         ST_RREQ: fl_addr = FA_W'(off) << PB_LOG2;
         default: fl_addr = '0;
      endcase
   end

   cfi_cmd_lanes #(.PORT_BYTES(PORT_BYTES), .CHIP_BYTES(CHIP_BYTES)) u_lanes (
      .cmd_i  (cmd_byte),
      .word_o (fl_wdata)
   );

   // sector map
   cfi_sector_table #(.DEPTH(MAX_SECTORS), .AW(ADDR_W)) u_tbl (
      .clk   (clk),
      .we    ((st == ST_EXP) && !full),
      .widx  (cnt[IDX_W-1:0]),
      .wdata (base_acc),
      .ridx  (tbl_idx),
      .rdata (tbl_base)
   );

   // result decoding
   cfi_pow2_sat #(.EW(9), .W(VAL_W)) u_dev (
      .exp_i (9'(esz) + 9'(RATIO_LOG2)),
      .val_o (dev_size)
   );

   cfi_pow2_sat #(.EW(16), .W(VAL_W)) u_wbuf (
      .exp_i (ebuf),
      .val_o (wbuf_size)
   );

   logic [VAL_W-1:0] tmo_v [3];
   for (genvar k = 0; k < 3; k++) begin : g_tmo
      cfi_pow2_sat #(.EW(9), .W(VAL_W)) u_tmo (
         .exp_i ({1'b0, typ[k]} + {1'b0, mx[k]}),
         .val_o (tmo_v[k])
      );
   end
   assign tmo_word  = tmo_v[0];
   assign tmo_buf   = tmo_v[1];
   assign tmo_erase = tmo_v[2];

   always_comb begin
      cmdset = CS_OTHER;
      if (valid_q) begin
         case (cs_id)
            16'd1, 16'd3: cmdset = CS_STATUS;
            16'd2, 16'd4: cmdset = CS_UNLOCK;
            default:      cmdset = CS_OTHER;
         endcase
      end
   end

   assign done       = (st == ST_DONE);
   assign valid      = valid_q;
   assign map_ovf    = ovf_q;
   assign sect_count = cnt;
endmodule

// File: rtl/cfi_probe_chk.sv
module cfi_probe_chk #(
   parameter int FA_W        = 16,
   parameter int CNT_W       = 7,
   parameter int MAX_SECTORS = 64
) (
   input logic             clk,
   input logic             rst,
   input logic             fl_rd,
   input logic             fl_we,
   input logic [FA_W-1:0]  fl_addr,
   input logic             done,
   input logic             valid,
   input logic [CNT_W-1:0] sect_count
);
   logic finished;
   always_ff @(posedge clk) begin
      if (rst)       finished <= 1'b0;
      else if (done) finished <= 1'b1;
   end

   assert_start_write_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (fl_we && fl_addr == '0));

   assert_valid_with_done_R4: assert property (@(posedge clk) disable iff (rst)
      !$stable(valid) |-> done);

   assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
      !$stable(sect_count) |-> (sect_count == $past(sect_count) + CNT_W'(1)));

   assert_count_cap_R11: assert property (@(posedge clk) disable iff (rst)
      sect_count <= CNT_W'(MAX_SECTORS));

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_done_after_reset_write_R12: assert property (@(posedge clk) disable iff (rst)
      done |-> ($past(fl_we) && $past(fl_addr) == '0));

   assert_quiet_after_done_R12: assert property (@(posedge clk) disable iff (rst)
      finished |-> (!fl_rd && !fl_we));

   assert_bus_excl_R13: assert property (@(posedge clk) disable iff (rst)
      !(fl_rd && fl_we));
endmodule

bind cfi_probe cfi_probe_chk #(
   .FA_W        (FA_W),
   .CNT_W       ($clog2(MAX_SECTORS + 1)),
   .MAX_SECTORS (MAX_SECTORS)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .fl_rd      (fl_rd),
   .fl_we      (fl_we),
   .fl_addr    (fl_addr),
   .done       (done),
   .valid      (valid),
   .sect_count (sect_count)
);

// File: tb/sim_cfi_probe.sv
`timescale 1ns/1ps
module sim_cfi_probe;
   localparam int PB = 4;
   localparam int CB = 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fl_rd, fl_we;
   logic [15:0] fl_addr;
   logic [31:0] fl_wdata;
   logic [31:0] fl_rdata = 32'h0;
   logic        done, valid, map_ovf;
   logic [1:0]  cmdset;
   logic [31:0] dev_size, wbuf_size, tmo_word, tmo_buf, tmo_erase, tbl_base;
   logic [6:0]  sect_count;
   logic [5:0]  tbl_idx = 6'd0;

   always #10 clk = ~clk;

   cfi_probe #(.PORT_BYTES(PB), .CHIP_BYTES(CB)) u0 (
      .clk(clk), .rst(rst), .fl_rd(fl_rd), .fl_we(fl_we), .fl_addr(fl_addr),
      .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .done(done), .valid(valid),
      .cmdset(cmdset), .dev_size(dev_size), .wbuf_size(wbuf_size),
      .tmo_word(tmo_word), .tmo_buf(tmo_buf), .tmo_erase(tmo_erase),
      .sect_count(sect_count), .map_ovf(map_ovf), .tbl_idx(tbl_idx), .tbl_base(tbl_base)
   );

   // flash model: query bytes in lane 0, junk above
   logic [7:0] q [64];
   logic       qm;
   always @(posedge clk) begin
      if (rst) qm <= 1'b0;
      else if (fl_we) begin
         if (fl_addr == 16'h0154 && fl_wdata == 32'h0098_0098) qm <= 1'b1;
         else if (fl_wdata == 32'h00FF_00FF)                   qm <= 1'b0;
      end
      if (fl_rd) fl_rdata <= qm ? {24'hA55A3C, q[fl_addr[7:2]]} : 32'hFFFF_FFFF;
   end

   // bus monitor, sampled away from the active edge
   int          cyc = 0, wr_n, misal, done_n, post_act, last_we_cyc, done_cyc;
   logic [15:0] w0a, w1a, wla;
   logic [31:0] w0d, w1d, wld;
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst) begin
         wr_n <= 0; misal <= 0; done_n <= 0; post_act <= 0;
         last_we_cyc <= 0; done_cyc <= 0;
         w0a <= '1; w1a <= '1; wla <= '1; w0d <= '0; w1d <= '0; wld <= '0;
      end else begin
         if (done_n != 0 && (fl_rd || fl_we)) post_act <= post_act + 1;
         if (fl_we) begin
            if (wr_n == 0) begin w0a <= fl_addr; w0d <= fl_wdata; end
            if (wr_n == 1) begin w1a <= fl_addr; w1d <= fl_wdata; end
            wla <= fl_addr; wld <= fl_wdata; last_we_cyc <= cyc;
            wr_n <= wr_n + 1;
         end
         if (fl_rd && fl_addr[1:0] != 2'b00) misal <= misal + 1;
         if (done) begin done_n <= done_n + 1; done_cyc <= cyc; end
      end
   end

   int n_chk = 0, n_fail = 0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] p2(int e);
      if (e >= 32) return 32'hFFFF_FFFF;
      return 32'd1 << e;
   endfunction

   function automatic logic [31:0] cs_of(int id);
      if (id == 1 || id == 3) return 32'd1;
      if (id == 2 || id == 4) return 32'd2;
      return 32'd0;
   endfunction

   // query table construction
   task automatic base_q(int id, int nreg);
      for (int i = 0; i < 64; i++) q[i] = 8'h00;
      q[16] = 8'h51; q[17] = 8'h52; q[18] = 8'h59;
      q[19] = 8'(id); q[20] = 8'(id >> 8);
      q[31] = 8'd4; q[32] = 8'd7; q[33] = 8'd10;
      q[35] = 8'd2; q[36] = 8'd3; q[37] = 8'd4;
      q[39] = 8'd22; q[42] = 8'd5; q[43] = 8'd0;
      q[44] = 8'(nreg);
   endtask

   task automatic set_reg(int r, int n, int units);
      int b = 45 + 4 * r;
      q[b]   = 8'(n - 1);
      q[b+1] = 8'((n - 1) >> 8);
      q[b+2] = 8'(units);
      q[b+3] = 8'(units >> 8);
   endtask

   logic [31:0] exp_tbl [64];
   int          exp_cnt;
   bit          exp_ov;

   task automatic calc_exp();
      int   cnt = 0;
      logic [31:0] a = 32'd0;
      logic [31:0] sz;
      bit   stop = 1'b0;
      exp_ov = (int'(q[44]) > 4);
      for (int r = 0; r < 4 && r < int'(q[44]) && !stop; r++) begin
         int b = 45 + 4 * r;
         int n = int'({q[b+1], q[b]}) + 1;
         int s = int'({q[b+3], q[b+2]});
         sz = (s == 0) ? 32'd128 : 32'(s) * 32'd256;
         sz = sz * 32'(PB / CB);
         for (int j = 0; j < n; j++) begin
            if (cnt == 64) begin exp_ov = 1'b1; stop = 1'b1; break; end
            exp_tbl[cnt] = a;
            a = a + sz;
            cnt++;
         end
      end
      exp_cnt = cnt;
   endtask

   task automatic run_probe(bit sig_exp, string tag);
      int t = 0;
      int bad = 0;
      rst = 1'b1;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      while (!done && t < 4000) begin @(negedge clk); t++; end
      if (t >= 4000) begin
         n_chk++; n_fail++;
         $display("FAIL R12 %s: probe hung, actual=no done expected=done", tag);
      end
      repeat (3) @(negedge clk);
      calc_exp();
      chk("R12", "done pulses", 32'(done_n), 32'd1);
      chk("R1", "first write addr", 32'(w0a), 32'h0);
      chk("R2", "first write data", w0d, 32'h00FF_00FF);
      chk("R1", "second write addr", 32'(w1a), 32'h154);
      chk("R2", "second write data", w1d, 32'h0098_0098);
      chk("R3", "misaligned reads", 32'(misal), 32'd0);
      chk("R12", "final write addr", 32'(wla), 32'h0);
      chk("R12", "final write data", wld, 32'h00FF_00FF);
      chk("R12", "done cycle after final write", 32'(done_cyc - last_we_cyc), 32'd1);
      chk("R12", "bus quiet after done", 32'(post_act), 32'd0);
      chk("R4", "valid", 32'(valid), 32'(sig_exp));
      if (!sig_exp) begin
         chk("R4", "cmdset on miss", 32'(cmdset), 32'd0);
         chk("R4", "count on miss", 32'(sect_count), 32'd0);
      end else begin
         chk("R5", "cmdset", 32'(cmdset), cs_of(int'({q[20], q[19]})));
         chk("R6", "dev_size", dev_size, p2(int'(q[39]) + 1));
         chk("R7", "wbuf_size", wbuf_size, p2(int'({q[43], q[42]})));
         chk("R8", "tmo_word", tmo_word, p2(int'(q[31]) + int'(q[35])));
         chk("R8", "tmo_buf", tmo_buf, p2(int'(q[32]) + int'(q[36])));
         chk("R8", "tmo_erase", tmo_erase, p2(int'(q[33]) + int'(q[37])));
         chk("R11", "sect_count", 32'(sect_count), 32'(exp_cnt));
         chk("R10", "map_ovf", 32'(map_ovf), 32'(exp_ov));
         for (int i = 0; i < exp_cnt; i++) begin
            tbl_idx = 6'(i);
            #1;
            if (tbl_base !== exp_tbl[i]) begin
               if (bad == 0)
                  $display("FAIL R9 %s: entry %0d actual=%0h expected=%0h", tag, i, tbl_base, exp_tbl[i]);
               bad++;
            end
         end
         n_chk++;
         if (bad != 0) n_fail++;
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // reset state
      repeat (3) @(negedge clk);
      chk("R12", "reset done", 32'(done), 32'd0);
      chk("R4", "reset valid", 32'(valid), 32'd0);
      chk("R11", "reset count", 32'(sect_count), 32'd0);
      chk("R10", "reset ovf", 32'(map_ovf), 32'd0);

      // typical two-region part
      base_q(1, 2); set_reg(0, 4, 32); set_reg(1, 3, 256);
      run_probe(1'b1, "typical");

      // signature miss on the second character
      base_q(2, 1); set_reg(0, 2, 1); q[17] = 8'h58;
      run_probe(1'b0, "bad signature");

      // more regions than supported: R10
      base_q(2, 5); set_reg(0, 2, 1); set_reg(1, 1, 0); set_reg(2, 3, 2); set_reg(3, 1, 4);
      run_probe(1'b1, "five regions");

      // exact fill on the last region: R11, no overflow
      base_q(3, 2); set_reg(0, 40, 1); set_reg(1, 24, 2);
      run_probe(1'b1, "exact capacity");

      // one past capacity: R11 overflow
      base_q(4, 2); set_reg(0, 40, 1); set_reg(1, 25, 2);
      run_probe(1'b1, "capacity plus one");

      // zero regions, unknown set, saturated size and timeouts
      base_q(7, 0); q[39] = 8'd31; q[42] = 8'd3; q[43] = 8'd1; q[33] = 8'd20; q[37] = 8'd12;
      run_probe(1'b1, "saturation");

      // size field zero (128-byte sectors) and large unit field
      base_q(3, 3); set_reg(0, 5, 0); set_reg(1, 2, 16'h0100); set_reg(2, 7, 0);
      run_probe(1'b1, "small sectors");

      // randomized tables
      for (int k = 0; k < 20; k++) begin
         int ids [6] = '{1, 2, 3, 4, 0, 7};
         int nr = int'($urandom_range(0, 5));
         base_q(ids[$urandom_range(0, 5)], nr);
         for (int i = 31; i <= 37; i++) q[i] = 8'($urandom_range(0, 20));
         q[34] = 8'h00; q[38] = 8'h00;
         q[39] = 8'($urandom_range(0, 34));
         q[42] = 8'($urandom_range(0, 33));
         q[43] = ($urandom_range(0, 7) == 0) ? 8'd1 : 8'd0;
         for (int r = 0; r < 4; r++)
            set_reg(r, int'($urandom_range(1, 30)),
                    ($urandom_range(0, 5) == 0) ? 16'h0200 : int'($urandom_range(0, 3)));
         run_probe(1'b1, "random");
      end

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 190000);
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule